// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache

This block is a small direct-mapped cache with one line per set. It sits between a byte-wide processor port and a main-memory port that returns one whole block for each read request. Each processor address is split into three fields: a tag, a set index and a byte offset. The index selects one line. That line holds a valid flag, a stored tag and a block of bytes.

A read hits when the selected line is valid and its stored tag equals the address tag. A hit completes in the same cycle as the request. A read miss stalls the processor. It issues a block request to memory, then overwrites the selected line with the returned block and delivers the requested byte in the cycle the response arrives. Writes always go to memory in the cycle they are presented. On a hit the cached byte is also updated. On a miss nothing is allocated and the resident line is left untouched. Two counters record the lookup outcomes for software-free performance observation.

Top module: `dm_wt_cache`

## Requirements
- R1: A processor address of ADDR_W bits splits into, from high to low, TAG_W = ADDR_W-IDX_W-OFF_W tag bits, IDX_W index bits and OFF_W offset bits. There are 2^IDX_W lines of 2^OFF_W bytes each. The default is ADDR_W=4, IDX_W=2, OFF_W=1.
- R2: A read whose line is valid with a matching tag asserts cpuReady in the same cycle as cpuReq. It returns on cpuRdata the cached byte selected by the offset, and it does not raise memReq.
- R3: A read miss raises memReq one cycle after the request. memAddr then holds the block-aligned address (offset bits zero) and stays stable until memRespValid. In the response cycle cpuReady is high and cpuRdata is byte k of memRespData (bits 8k+7..8k, where k is the offset). The line then takes the new tag and data.
- R4: Starting from reset with default parameters, byte reads of addresses 0, 1, 7, 8, 0 give miss, hit, miss, miss, miss. Address 8 displaces the block holding bytes 0 and 1.
- R5: A write hit completes in the cycle it is presented, with memWe high, memAddr equal to cpuAddr and memWdata equal to cpuWdata. A later read of that byte hits and returns the new value.
- R6: A write miss completes in one cycle with the same memory write as R5. It leaves the line unchanged, so the resident block still hits and the written address still misses.
- R7: A synchronous active-high rst invalidates every line, zeroes both counters and returns the control to idle with memReq low.
- R8: hitCount rises by one for every hit (read or write) and missCount by one for every miss (read or write). A read miss is counted once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cpuReq | input | 1 | Access request, held until cpuReady |
| cpuWe | input | 1 | 1 = byte write, 0 = byte read |
| cpuAddr | input | ADDR_W | Byte address |
| cpuWdata | input | 8 | Write byte |
| cpuReady | output | 1 | Access completes this cycle |
| cpuRdata | output | 8 | Read byte, valid with cpuReady on reads |
| memReq | output | 1 | Block read request, held until memRespValid |
| memWe | output | 1 | Byte write to memory this cycle |
| memAddr | output | ADDR_W | Block-aligned read address or byte write address |
| memWdata | output | 8 | Byte written to memory |
| memRespValid | input | 1 | One-cycle pulse carrying the requested block |
| memRespData | input | 8*2^OFF_W | Block bytes, byte k in bits 8k+7..8k |
| hitCount | output | CNT_W | Number of hits |
| missCount | output | CNT_W | Number of misses |

## Verification
The bench replays the conflict trace 0, 1, 7, 8, 0. A cache that compared only the index, or never evicted, would report a hit on the final read. A write to a conflicting address while another block is resident catches a design that allocates on write misses: the resident block would then miss and the written address would hit. A write hit followed by a read detects a line that is not updated, which would return the stale byte. A mix of randomly latent memory responses and random accesses, a mid-run reset and final counter comparisons expose counters that double-count a refill or ignore writes.

// File: rtl/dmc_pkg.sv
`timescale 1ns/1ps
package dmc_pkg;

  // Strobes from the control to the datapath for one cycle
  typedef struct packed {
    logic writeHit;   // update cached byte at lookup address
    logic fillLine;   // install the response block into the latched line
    logic latchAddr;  // capture the missing address
    logic fillSel;    // route response byte and block address outward
    logic cntHit;     // count one hit
    logic cntMiss;    // count one miss
  } dmc_ctrl_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } dmc_state_e;

endpackage

// File: rtl/dmc_counter.sv
`timescale 1ns/1ps
module dmc_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)      count <= '0;
    else if (inc) count <= count + 1'b1;
  end
endmodule

// File: rtl/dmc_ctrl.sv
`timescale 1ns/1ps
module dmc_ctrl
  import dmc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      cpuReq,
  input  logic      cpuWe,
  input  logic      lookupHit,
  input  logic      memRespValid,
  output logic      cpuReady,
  output logic      memReq,
  output logic      memWe,
  output dmc_ctrl_t ctl
);
  dmc_state_e state, stateNext;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    ctl       = '0;
    cpuReady  = 1'b0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (cpuReq) begin
          if (cpuWe) begin
            // write-through, no allocation on miss
            cpuReady     = 1'b1;
            memWe        = 1'b1;
            ctl.writeHit = lookupHit;
            ctl.cntHit   = lookupHit;
            ctl.cntMiss  = !lookupHit;
          end else if (lookupHit) begin
            cpuReady   = 1'b1;
            ctl.cntHit = 1'b1;
          end else begin
            ctl.latchAddr = 1'b1;
            ctl.cntMiss   = 1'b1;
            stateNext     = ST_FILL;
          end
        end
      end
      ST_FILL: begin
        memReq      = 1'b1;
        ctl.fillSel = 1'b1;
        if (memRespValid) begin
          ctl.fillLine = 1'b1;
          cpuReady     = 1'b1;
          stateNext    = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/dmc_datapath.sv
`timescale 1ns/1ps
module dmc_datapath
  import dmc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int IDX_W  = 2,
  parameter int OFF_W  = 1,
  parameter int CNT_W  = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  dmc_ctrl_t                      ctl,
  input  logic [ADDR_W-1:0]              cpuAddr,
  input  logic [7:0]                     cpuWdata,
  input  logic [8*(1<<OFF_W)-1:0]        memRespData,
  output logic                           lookupHit,
  output logic [7:0]                     cpuRdata,
  output logic [ADDR_W-1:0]              memAddr,
  output logic [7:0]                     memWdata,
  output logic [CNT_W-1:0]               hitCount,
  output logic [CNT_W-1:0]               missCount
);
  localparam int TAG_W     = ADDR_W - IDX_W - OFF_W;
  localparam int SETS      = 1 << IDX_W;
  localparam int BLK_BYTES = 1 << OFF_W;

  // address fields
  logic [TAG_W-1:0] addrTag;
  logic [IDX_W-1:0] addrIdx;
  logic [OFF_W-1:0] addrOff;
  assign addrTag = cpuAddr[ADDR_W-1 -: TAG_W];
  assign addrIdx = cpuAddr[OFF_W +: IDX_W];
  assign addrOff = cpuAddr[OFF_W-1:0];

  // line storage
  logic             validBits [SETS];
  logic [TAG_W-1:0] tagMem    [SETS];
  logic [7:0]       dataMem   [SETS][BLK_BYTES];

  // captured miss address
  logic [TAG_W-1:0] latTag;
  logic [IDX_W-1:0] latIdx;
  logic [OFF_W-1:0] latOff;

  // response block as bytes
  logic [7:0] respBytes [BLK_BYTES];
  for (genvar k = 0; k < BLK_BYTES; k++) begin : g_resp
    assign respBytes[k] = memRespData[8*k +: 8];
  end

  always_ff @(posedge clk) begin
    if (ctl.latchAddr) begin
      latTag <= addrTag;
      latIdx <= addrIdx;
      latOff <= addrOff;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SETS; i++) validBits[i] <= 1'b0;
    end else if (ctl.fillLine) begin
      validBits[latIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.fillLine) begin
      tagMem[latIdx] <= latTag;
      for (int k = 0; k < BLK_BYTES; k++) dataMem[latIdx][k] <= respBytes[k];
    end else if (ctl.writeHit) begin
      dataMem[addrIdx][addrOff] <= cpuWdata;
    end
  end

  assign lookupHit = validBits[addrIdx] && (tagMem[addrIdx] == addrTag);
  assign cpuRdata  = ctl.fillSel ? respBytes[latOff] : dataMem[addrIdx][addrOff];
  assign memAddr   = ctl.fillSel ? {latTag, latIdx, {OFF_W{1'b0}}} : cpuAddr;
  assign memWdata  = cpuWdata;

  dmc_counter #(.W(CNT_W)) u_hitCnt (
    .clk(clk), .rst(rst), .inc(ctl.cntHit), .count(hitCount)
  );
  dmc_counter #(.W(CNT_W)) u_missCnt (
    .clk(clk), .rst(rst), .inc(ctl.cntMiss), .count(missCount)
  );
endmodule

// File: rtl/dm_wt_cache.sv
`timescale 1ns/1ps
module dm_wt_cache
  import dmc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int IDX_W  = 2,
  parameter int OFF_W  = 1,
  parameter int CNT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cpuReq,
  input  logic                    cpuWe,
  input  logic [ADDR_W-1:0]       cpuAddr,
  input  logic [7:0]              cpuWdata,
  output logic                    cpuReady,
  output logic [7:0]              cpuRdata,
  output logic                    memReq,
  output logic                    memWe,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [7:0]              memWdata,
  input  logic                    memRespValid,
  input  logic [8*(1<<OFF_W)-1:0] memRespData,
  output logic [CNT_W-1:0]        hitCount,
  output logic [CNT_W-1:0]        missCount
);
  dmc_ctrl_t ctl;
  logic      lookupHit;

  dmc_ctrl u_ctrl (
    .clk(clk), .rst(rst), .cpuReq(cpuReq), .cpuWe(cpuWe),
    .lookupHit(lookupHit), .memRespValid(memRespValid),
    .cpuReady(cpuReady), .memReq(memReq), .memWe(memWe), .ctl(ctl)
  );

  dmc_datapath #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .memRespData(memRespData), .lookupHit(lookupHit), .cpuRdata(cpuRdata),
    .memAddr(memAddr), .memWdata(memWdata),
    .hitCount(hitCount), .missCount(missCount)
  );
endmodule

// File: rtl/dmc_checker.sv
`timescale 1ns/1ps
module dmc_checker #(
  parameter int ADDR_W = 4,
  parameter int OFF_W  = 1,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cpuReq,
  input logic              cpuWe,
  input logic [ADDR_W-1:0] cpuAddr,
  input logic [7:0]        cpuWdata,
  input logic              cpuReady,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [7:0]        memWdata,
  input logic              memRespValid,
  input logic [CNT_W-1:0]  hitCount,
  input logic [CNT_W-1:0]  missCount
);
  // R3: block request held with a stable address until answered
  a_r3_req_held: assert property (@(posedge clk) disable iff (rst)
    memReq && !memRespValid |=> memReq && $stable(memAddr));

  // R3: block request address is aligned
  a_r3_aligned: assert property (@(posedge clk) disable iff (rst)
    memReq |-> memAddr[OFF_W-1:0] == '0);

  // R3: response completes the stalled read
  a_r3_resp_ready: assert property (@(posedge clk) disable iff (rst)
    memReq && memRespValid |-> cpuReady);

  // R2: a completion without a response never fetches
  a_r2_no_fetch: assert property (@(posedge clk) disable iff (rst)
    cpuReady && !memRespValid |-> !memReq);

  // R5 / R6: every write goes through in the cycle presented
  a_r5_write_through: assert property (@(posedge clk) disable iff (rst)
    cpuReq && cpuWe |-> cpuReady && memWe && memAddr == cpuAddr && memWdata == cpuWdata);

  // R6: memory writes only come from processor writes, never with a fetch
  a_r6_write_source: assert property (@(posedge clk) disable iff (rst)
    memWe |-> cpuReq && cpuWe && !memReq);

  // R7: reset clears counters and fetch
  a_r7_reset: assert property (@(posedge clk)
    rst |=> hitCount == '0 && missCount == '0 && !memReq);

  // R8: counters step by at most one
  a_r8_hit_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> CNT_W'(hitCount - $past(hitCount)) <= CNT_W'(1));
  a_r8_miss_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> CNT_W'(missCount - $past(missCount)) <= CNT_W'(1));
endmodule

bind dm_wt_cache dmc_checker #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
  .cpuWdata(cpuWdata), .cpuReady(cpuReady), .memReq(memReq), .memWe(memWe),
  .memAddr(memAddr), .memWdata(memWdata), .memRespValid(memRespValid),
  .hitCount(hitCount), .missCount(missCount)
);

// File: tb/dm_wt_cache_bench.sv
`timescale 1ns/100ps
module dm_wt_cache_bench;
  localparam int AW = 4;
  localparam int IW = 2;
  localparam int OW = 1;
  localparam int CW = 16;
  localparam int TW = AW - IW - OW;
  localparam int NS = 1 << IW;
  localparam int NB = 1 << OW;
  localparam int NM = 1 << AW;

  logic          clk = 1'b0;
  logic          rst;
  logic          cpuReq, cpuWe;
  logic [AW-1:0] cpuAddr;
  logic [7:0]    cpuWdata;
  logic          cpuReady;
  logic [7:0]    cpuRdata;
  logic          memReq, memWe;
  logic [AW-1:0] memAddr;
  logic [7:0]    memWdata;
  logic          memRespValid;
  logic [8*NB-1:0] memRespData;
  logic [CW-1:0] hitCount, missCount;

  always #2 clk = ~clk;   // 250 MHz

  dm_wt_cache #(.ADDR_W(AW), .IDX_W(IW), .OFF_W(OW), .CNT_W(CW)) u_dm_wt_cache (
    .clk(clk), .rst(rst), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuReady(cpuReady), .cpuRdata(cpuRdata),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRespValid(memRespValid), .memRespData(memRespData),
    .hitCount(hitCount), .missCount(missCount)
  );

  int nChecks = 0;
  int nFails  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // memory seen through the design's ports, and the specification model
  logic [7:0] memModel [NM];
  logic [7:0] refMem   [NM];
  logic       refValid [NS];
  logic [TW-1:0] refTag [NS];
  int expHits = 0;
  int expMisses = 0;

  typedef struct {
    bit         isWr;
    bit         hit;
    logic [AW-1:0] addr;
    logic [7:0] data;
    string      req;
  } item_t;
  item_t sbq[$];

  // memory responder: variable latency, one-cycle block pulse
  int waitCnt = 0;
  int lat = 1;
  initial begin
    memRespValid = 1'b0;
    memRespData  = '0;
    forever begin
      @(negedge clk);
      if (memRespValid) begin
        memRespValid = 1'b0;
      end else if (memReq && !rst) begin
        waitCnt++;
        if (waitCnt >= lat) begin
          for (int k = 0; k < NB; k++)
            memRespData[8*k +: 8] = memModel[{memAddr[AW-1:OW], OW'(k)}];
          memRespValid = 1'b1;
          waitCnt = 0;
          lat = 1 + int'($urandom % 3);
        end
      end
    end
  end

  // monitor: pops expected items at each completion
  int stall = 0;
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (memWe && !rst) memModel[memAddr] = memWdata;
      if (cpuReq && !rst) begin
        if (cpuReady) begin
          if (sbq.size() == 0) begin
            check(1'b0, "R2", "unexpected completion", 1, 0);
          end else begin
            item_t it;
            it = sbq.pop_front();
            if (it.isWr) begin
              check(stall == 0, it.req, "write stall cycles", stall, 0);
              check(memWe && memAddr == it.addr && memWdata == it.data, it.req,
                    "write-through byte", int'(memWdata), int'(it.data));
            end else if (it.hit) begin
              check(stall == 0 && !memReq, it.req, "hit stall cycles", stall, 0);
              check(cpuRdata == it.data, it.req, "hit data", int'(cpuRdata), int'(it.data));
            end else begin
              check(stall > 0, it.req, "miss must stall", stall, 1);
              check(cpuRdata == it.data, it.req, "miss data", int'(cpuRdata), int'(it.data));
            end
          end
          stall = 0;
        end else begin
          stall++;
        end
      end
    end
  end

  task automatic access(input bit wr, input logic [AW-1:0] a, input logic [7:0] d,
                        input string req);
    item_t it;
    logic [IW-1:0] idx;
    logic [TW-1:0] tg;
    idx = a[OW +: IW];
    tg  = a[AW-1 -: TW];
    it.isWr = wr;
    it.addr = a;
    it.hit  = refValid[idx] && (refTag[idx] == tg);
    if (it.hit) expHits++; else expMisses++;
    if (wr) begin
      refMem[a] = d;
      it.data = d;
    end else begin
      it.data = refMem[a];
      if (!it.hit) begin
        refValid[idx] = 1'b1;
        refTag[idx]   = tg;
      end
    end
    if (req == "")
      it.req = wr ? (it.hit ? "R5" : "R6") : (it.hit ? "R2" : "R3");
    else
      it.req = req;
    sbq.push_back(it);
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = wr; cpuAddr = a; cpuWdata = d;
    forever begin
      #1;
      if (cpuReady) break;
      @(negedge clk);
    end
    @(negedge clk);
    cpuReq = 1'b0; cpuWe = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NS; i++) refValid[i] = 1'b0;
    expHits = 0;
    expMisses = 0;
  endtask

  task automatic checkCounts(input string req);
    @(negedge clk);
    #1;
    check(int'(hitCount) == expHits, req, "hitCount", int'(hitCount), expHits);
    check(int'(missCount) == expMisses, req, "missCount", int'(missCount), expMisses);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    rst = 1'b1; cpuReq = 1'b0; cpuWe = 1'b0; cpuAddr = '0; cpuWdata = '0;
    for (int i = 0; i < NM; i++) begin
      memModel[i] = 8'hA0 + 8'(i);
      refMem[i]   = 8'hA0 + 8'(i);
    end
    for (int i = 0; i < NS; i++) begin
      refValid[i] = 1'b0;
      refTag[i] = '0;
    end
    repeat (3) @(negedge clk);
    #1;
    // R7: reset state
    check(!memReq && !cpuReady, "R7", "idle after reset", int'(memReq), 0);
    check(hitCount == 0 && missCount == 0, "R7", "counters after reset",
          int'(hitCount) + int'(missCount), 0);
    @(negedge clk);
    rst = 1'b0;

    // R4: conflict trace 0,1,7,8,0 -> miss,hit,miss,miss,miss
    access(1'b0, 4'd0, 8'h00, "R4");
    access(1'b0, 4'd1, 8'h00, "R4");
    access(1'b0, 4'd7, 8'h00, "R4");
    access(1'b0, 4'd8, 8'h00, "R4");
    access(1'b0, 4'd0, 8'h00, "R4");
    checkCounts("R4");

    // R5: write hit then read hit returns new byte
    access(1'b1, 4'd0, 8'h55, "R5");
    access(1'b0, 4'd0, 8'h00, "R5");
    // R6: write miss to conflicting block 9, no allocation
    access(1'b1, 4'd9, 8'h3C, "R6");
    access(1'b0, 4'd1, 8'h00, "R6");
    access(1'b0, 4'd9, 8'h00, "R6");
    checkCounts("R8");

    // R1: sweep every address twice, all fields exercised
    for (int r = 0; r < 2; r++)
      for (int a = 0; a < NM; a++)
        access(1'b0, AW'(a), 8'h00, "R1");
    checkCounts("R1");

    // R7: reset invalidates lines
    doReset();
    checkCounts("R7");
    access(1'b0, 4'd9, 8'h00, "R7");

    // mixed random traffic
    for (int n = 0; n < 300; n++) begin
      logic [AW-1:0] a;
      a = AW'($urandom % NM);
      if (($urandom % 3) == 0) access(1'b1, a, 8'($urandom), "");
      else                     access(1'b0, a, 8'h00, "");
    end
    checkCounts("R8");

    // R5 / R6: memory contents match the write-through model
    for (int i = 0; i < NM; i++)
      check(memModel[i] == refMem[i], "R5", "memory byte", int'(memModel[i]), int'(refMem[i]));
    check(sbq.size() == 0, "R8", "pending items", sbq.size(), 0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule